// File: doc/BRIEF.md
# Transmit Packet Framer

This block builds a complete transmit packet around a payload that a host has placed in a FIFO. Once a send is started it produces one serial bit per clock. The bits form, in turn, an alternating preamble, a sync word, an optional header, an optional length byte, the payload read from the FIFO, and an optional 16-bit CRC. The framing fields come from configuration inputs that are captured when the send is accepted, so the host never has to write framing bytes into the FIFO.

The FIFO is a show-ahead FIFO: `fifo_rdata` is valid whenever `fifo_empty` is low, and `fifo_rd` pops one entry. If the FIFO runs dry while a payload byte is needed, the packet is cut short and an error flag is raised. A one-cycle done pulse marks the last bit of a packet that completes normally.

Top module: `pkt_framer_tx`

## Requirements
- R1: A packet is sent as preamble, sync word, header, length byte, payload and CRC, in that order, and a field of zero length is skipped with no gap in the stream.
- R2: The preamble is `cfg_pre_bytes` copies of the byte 0x55, so the very first bit of every packet is 0 and bits then alternate; a value of 0 is sent as one preamble byte.
- R3: The sync word is `cfg_sync_len`+1 bytes (1 to 4) and the header is `cfg_hdr_len` bytes (0 to 4, values above 4 send 4); both are taken from their 32-bit word starting with bits [31:24] and moving toward bit 0.
- R4: Every byte is sent most-significant bit first, and `tx_valid` stays high without a break from the first bit of a packet to its last bit.
- R5: With `cfg_len_en` high a length byte equal to `cfg_pay_len` is sent; the payload is exactly `cfg_pay_len` bytes, each popped once from the FIFO, and `fifo_rd` is never high while `fifo_empty` is high or the block is idle.
- R6: With `cfg_crc_en` high two CRC bytes follow, high byte first; the CRC covers header, length and payload bytes only, starts from 0xFFFF, is not reflected and has no final inversion; `cfg_crc_sel`=0 uses polynomial 0x8005 and 1 uses 0x1021.
- R7: `tx_done` is a single-cycle pulse that coincides with the final `tx_valid` bit, and `busy` is low in that cycle.
- R8: If the FIFO is empty when a payload byte is needed, no further bits are sent, `tx_done` does not pulse, and `tx_err` goes high and stays high until the next accepted start.
- R9: A start is accepted only while `busy` is low; a start while busy is ignored and configuration changes during a packet do not affect it.
- R10: After reset `tx_valid`, `tx_bit`, `tx_done`, `tx_err`, `busy` and `fifo_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (accepted when idle) |
| cfg_pre_bytes | input | 8 | Preamble length in bytes |
| cfg_sync_len | input | 2 | Sync word length minus one |
| cfg_sync_word | input | 32 | Sync bytes, first sent in [31:24] |
| cfg_hdr_len | input | 3 | Header length in bytes |
| cfg_hdr_word | input | 32 | Header bytes, first sent in [31:24] |
| cfg_len_en | input | 1 | Insert the length byte |
| cfg_pay_len | input | 8 | Payload byte count |
| cfg_crc_en | input | 1 | Append the 2-byte CRC |
| cfg_crc_sel | input | 1 | 0: poly 0x8005, 1: poly 0x1021 |
| fifo_empty | input | 1 | Payload FIFO has no data |
| fifo_rdata | input | 8 | Head entry of the payload FIFO |
| fifo_rd | output | 1 | Pop the head entry |
| tx_bit | output | 1 | Serial data bit |
| tx_valid | output | 1 | `tx_bit` is a packet bit |
| tx_done | output | 1 | Pulse on the last bit of a good packet |
| tx_err | output | 1 | Payload underflow flag |
| busy | output | 1 | A packet is in progress |

## Verification
The hardest state to reach is a FIFO that runs dry part-way through the payload, after the CRC has already absorbed some payload bytes and while the serializer still holds the previous byte. The bench preloads fewer bytes than the programmed payload count, so the starvation arrives at a byte boundary deep inside the payload; it then checks that the stream stops right after the last popped byte, that no done pulse appears, and that the error flag persists until the following start clears it.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

  typedef enum logic [2:0] {
    FLD_PRE  = 3'd0,
    FLD_SYNC = 3'd1,
    FLD_HDR  = 3'd2,
    FLD_LEN  = 3'd3,
    FLD_PAY  = 3'd4,
    FLD_CRC  = 3'd5,
    FLD_END  = 3'd6
  } fld_e;

  localparam int          FLD_N      = 7;
  localparam int          CRC_W      = 16;
  localparam logic [15:0] POLY_IBM   = 16'h8005;
  localparam logic [15:0] POLY_CCITT = 16'h1021;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;

endpackage

// File: rtl/pf_crc16.sv
module pf_crc16 #(
  parameter int BYTE_W = 8
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                clear,
  input  logic                                feed,
  input  logic                                sel,
  input  logic [BYTE_W-1:0]                   din,
  output logic [pkt_framer_pkg::CRC_W-1:0]    crc
);
  import pkt_framer_pkg::*;

  logic [CRC_W-1:0] poly;
  logic [CRC_W-1:0] nxt;

  // Byte-parallel update, MSB of the byte first.
  always_comb begin
    logic fb;
    poly = sel ? POLY_CCITT : POLY_IBM;
    nxt  = crc;
    for (int b = BYTE_W - 1; b >= 0; b--) begin
      fb  = nxt[CRC_W-1] ^ din[b];
      nxt = {nxt[CRC_W-2:0], 1'b0};
      if (fb) nxt = nxt ^ poly;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= CRC_SEED;
    else if (feed)    crc <= nxt;
  end

endmodule

// File: rtl/pf_serializer.sv
module pf_serializer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              byte_end,
  output logic              tx_bit,
  output logic              tx_valid
);
  localparam int             CW   = $clog2(BYTE_W);
  localparam logic [CW-1:0]  LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic              act;

  // High while the final bit of the held byte is being moved out.
  assign byte_end = act && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      cnt      <= '0;
      act      <= 1'b0;
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= act;
      tx_bit   <= act ? shreg[BYTE_W-1] : 1'b0;
      if (load) begin
        shreg <= din;
        cnt   <= '0;
        act   <= 1'b1;
      end else if (act) begin
        shreg <= {shreg[BYTE_W-2:0], 1'b0};
        cnt   <= cnt + 1'b1;
        if (byte_end) act <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pf_field_seq.sv
module pf_field_seq #(
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 8,
  parameter int SYNC_MAX = 4,
  parameter int HDR_MAX  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [PRE_W-1:0]                  cfg_pre_bytes,
  input  logic [$clog2(SYNC_MAX)-1:0]       cfg_sync_len,
  input  logic [SYNC_MAX*BYTE_W-1:0]        cfg_sync_word,
  input  logic [$clog2(HDR_MAX+1)-1:0]      cfg_hdr_len,
  input  logic [HDR_MAX*BYTE_W-1:0]         cfg_hdr_word,
  input  logic                              cfg_len_en,
  input  logic [BYTE_W-1:0]                 cfg_pay_len,
  input  logic                              cfg_crc_en,
  input  logic                              cfg_crc_sel,
  input  logic                              fifo_empty,
  input  logic [BYTE_W-1:0]                 fifo_rdata,
  input  logic                              byte_end,
  input  logic [pkt_framer_pkg::CRC_W-1:0]  crc_val,
  output logic                              fifo_rd,
  output logic                              ld,
  output logic [BYTE_W-1:0]                 ld_byte,
  output logic                              crc_clear,
  output logic                              crc_feed,
  output logic                              crc_sel,
  output logic                              busy,
  output logic                              done,
  output logic                              err
);
  import pkt_framer_pkg::*;

  localparam int CNT_W  = (PRE_W > BYTE_W) ? PRE_W : BYTE_W;
  localparam int SYNC_W = SYNC_MAX * BYTE_W;
  localparam int HDR_W  = HDR_MAX * BYTE_W;
  localparam logic [BYTE_W-1:0] PRE_BYTE = {(BYTE_W/2){2'b01}};

  // Captured configuration
  logic [CNT_W-1:0]  pre_n, sync_n, hdr_n, pay_n;
  logic              len_en_q, crc_en_q, sel_q;
  logic [SYNC_W-1:0] sync_q;
  logic [HDR_W-1:0]  hdr_q;

  // Position of the next byte to load
  fld_e              fld;
  logic [CNT_W-1:0]  idx;
  logic              kick;

  logic [CNT_W-1:0]  flen [FLD_N];
  logic [CNT_W-1:0]  cur_len;
  logic              last_of_fld;
  fld_e              nxt_fld;
  logic              want, underflow, finish, accept;
  logic [SYNC_W-1:0] sync_sh;
  logic [HDR_W-1:0]  hdr_sh;

  assign accept = start && !busy;

  always_comb begin
    flen[FLD_PRE]  = pre_n;
    flen[FLD_SYNC] = sync_n;
    flen[FLD_HDR]  = hdr_n;
    flen[FLD_LEN]  = len_en_q ? CNT_W'(1) : '0;
    flen[FLD_PAY]  = pay_n;
    flen[FLD_CRC]  = crc_en_q ? CNT_W'(CRC_W / BYTE_W) : '0;
    flen[FLD_END]  = '0;
  end

  assign cur_len     = flen[fld];
  assign last_of_fld = (idx == cur_len - CNT_W'(1));

  // First non-empty field after the current one
  always_comb begin
    nxt_fld = FLD_END;
    for (int k = FLD_N - 2; k >= 0; k--) begin
      if (k > int'(fld) && flen[k] != '0) nxt_fld = fld_e'(k[2:0]);
    end
  end

  assign want      = busy && (kick || byte_end);
  assign underflow = want && (fld == FLD_PAY) && fifo_empty;
  assign finish    = want && (fld == FLD_END);
  assign ld        = want && !underflow && !finish;

  assign sync_sh = sync_q << (int'(idx) * BYTE_W);
  assign hdr_sh  = hdr_q  << (int'(idx) * BYTE_W);

  always_comb begin
    unique case (fld)
      FLD_PRE:  ld_byte = PRE_BYTE;
      FLD_SYNC: ld_byte = sync_sh[SYNC_W-1 -: BYTE_W];
      FLD_HDR:  ld_byte = hdr_sh[HDR_W-1 -: BYTE_W];
      FLD_LEN:  ld_byte = pay_n[BYTE_W-1:0];
      FLD_PAY:  ld_byte = fifo_rdata;
      FLD_CRC:  ld_byte = (idx == '0) ? crc_val[CRC_W-1 -: BYTE_W]
                                      : crc_val[BYTE_W-1:0];
      default:  ld_byte = '0;
    endcase
  end

  assign fifo_rd   = ld && (fld == FLD_PAY);
  assign crc_feed  = ld && (fld == FLD_HDR || fld == FLD_LEN || fld == FLD_PAY);
  assign crc_clear = accept;
  assign crc_sel   = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      kick     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      fld      <= FLD_PRE;
      idx      <= '0;
      pre_n    <= CNT_W'(1);
      sync_n   <= CNT_W'(1);
      hdr_n    <= '0;
      pay_n    <= '0;
      len_en_q <= 1'b0;
      crc_en_q <= 1'b0;
      sel_q    <= 1'b0;
      sync_q   <= '0;
      hdr_q    <= '0;
    end else begin
      done <= 1'b0;
      kick <= 1'b0;
      if (accept) begin
        pre_n    <= (cfg_pre_bytes == '0) ? CNT_W'(1) : CNT_W'(cfg_pre_bytes);
        sync_n   <= CNT_W'(cfg_sync_len) + CNT_W'(1);
        hdr_n    <= (int'(cfg_hdr_len) > HDR_MAX) ? CNT_W'(HDR_MAX) : CNT_W'(cfg_hdr_len);
        pay_n    <= CNT_W'(cfg_pay_len);
        len_en_q <= cfg_len_en;
        crc_en_q <= cfg_crc_en;
        sel_q    <= cfg_crc_sel;
        sync_q   <= cfg_sync_word;
        hdr_q    <= cfg_hdr_word;
        busy     <= 1'b1;
        kick     <= 1'b1;
        err      <= 1'b0;
        fld      <= FLD_PRE;
        idx      <= '0;
      end else if (underflow) begin
        busy <= 1'b0;
        err  <= 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (ld) begin
        if (last_of_fld) begin
          fld <= nxt_fld;
          idx <= '0;
        end else begin
          idx <= idx + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pkt_framer_tx.sv
module pkt_framer_tx #(
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 8,
  parameter int SYNC_MAX = 4,
  parameter int HDR_MAX  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [PRE_W-1:0]              cfg_pre_bytes,
  input  logic [$clog2(SYNC_MAX)-1:0]   cfg_sync_len,
  input  logic [SYNC_MAX*BYTE_W-1:0]    cfg_sync_word,
  input  logic [$clog2(HDR_MAX+1)-1:0]  cfg_hdr_len,
  input  logic [HDR_MAX*BYTE_W-1:0]     cfg_hdr_word,
  input  logic                          cfg_len_en,
  input  logic [BYTE_W-1:0]             cfg_pay_len,
  input  logic                          cfg_crc_en,
  input  logic                          cfg_crc_sel,
  input  logic                          fifo_empty,
  input  logic [BYTE_W-1:0]             fifo_rdata,
  output logic                          fifo_rd,
  output logic                          tx_bit,
  output logic                          tx_valid,
  output logic                          tx_done,
  output logic                          tx_err,
  output logic                          busy
);
  import pkt_framer_pkg::*;

  logic              byte_end, ld, crc_clear, crc_feed, crc_sel;
  logic [BYTE_W-1:0] ld_byte;
  logic [CRC_W-1:0]  crc_val;

  pf_field_seq #(
    .BYTE_W(BYTE_W), .PRE_W(PRE_W), .SYNC_MAX(SYNC_MAX), .HDR_MAX(HDR_MAX)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync_len(cfg_sync_len),
    .cfg_sync_word(cfg_sync_word), .cfg_hdr_len(cfg_hdr_len),
    .cfg_hdr_word(cfg_hdr_word), .cfg_len_en(cfg_len_en),
    .cfg_pay_len(cfg_pay_len), .cfg_crc_en(cfg_crc_en),
    .cfg_crc_sel(cfg_crc_sel), .fifo_empty(fifo_empty),
    .fifo_rdata(fifo_rdata), .byte_end(byte_end), .crc_val(crc_val),
    .fifo_rd(fifo_rd), .ld(ld), .ld_byte(ld_byte),
    .crc_clear(crc_clear), .crc_feed(crc_feed), .crc_sel(crc_sel),
    .busy(busy), .done(tx_done), .err(tx_err)
  );

  pf_crc16 #(.BYTE_W(BYTE_W)) u_crc (
    .clk(clk), .rst(rst), .clear(crc_clear), .feed(crc_feed),
    .sel(crc_sel), .din(ld_byte), .crc(crc_val)
  );

  pf_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst(rst), .load(ld), .din(ld_byte),
    .byte_end(byte_end), .tx_bit(tx_bit), .tx_valid(tx_valid)
  );

endmodule

// File: rtl/pkt_framer_tx_chk.sv
module pkt_framer_tx_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic fifo_rd,
  input logic fifo_empty,
  input logic tx_valid,
  input logic tx_done,
  input logic tx_err
);
  logic err_d;
  always_ff @(posedge clk) begin
    if (rst) err_d <= 1'b0;
    else     err_d <= tx_err;
  end

  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);

  a_r5_pop_busy: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> busy);

  a_r4_no_gap: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_done && !(tx_err && !err_d)) |=> tx_valid);

  a_r7_done_on_bit: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (tx_valid && !busy));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_done);

  a_r8_abort_no_done: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !err_d) |-> !tx_done);

  a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !(start && !busy)) |=> tx_err);

  a_r9_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!tx_valid && !busy && !tx_done && !tx_err && !fifo_rd));

endmodule

bind pkt_framer_tx pkt_framer_tx_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .fifo_rd(fifo_rd),
  .fifo_empty(fifo_empty), .tx_valid(tx_valid), .tx_done(tx_done),
  .tx_err(tx_err)
);

// File: tb/sim_pkt_framer_tx.sv
`timescale 1ns/1ps
module sim_pkt_framer_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  c_pre = 8'd1;
  logic [1:0]  c_sync_len = 2'd0;
  logic [31:0] c_sync_word = 32'h0;
  logic [2:0]  c_hdr_len = 3'd0;
  logic [31:0] c_hdr_word = 32'h0;
  logic        c_len_en = 1'b0;
  logic [7:0]  c_pay_len = 8'd0;
  logic        c_crc_en = 1'b0;
  logic        c_crc_sel = 1'b0;
  logic        fifo_empty, fifo_rd, tx_bit, tx_valid, tx_done, tx_err, busy;
  logic [7:0]  fifo_rdata;

  always #2.5 clk = ~clk;

  pkt_framer_tx u0 (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pre_bytes(c_pre), .cfg_sync_len(c_sync_len), .cfg_sync_word(c_sync_word),
    .cfg_hdr_len(c_hdr_len), .cfg_hdr_word(c_hdr_word), .cfg_len_en(c_len_en),
    .cfg_pay_len(c_pay_len), .cfg_crc_en(c_crc_en), .cfg_crc_sel(c_crc_sel),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .tx_done(tx_done), .tx_err(tx_err),
    .busy(busy)
  );

  // Show-ahead FIFO model
  logic [7:0] fmem [0:63];
  int rp = 0;
  int wp = 0;
  assign fifo_empty = (rp == wp);
  assign fifo_rdata = fmem[rp[5:0]];
  always @(posedge clk) begin
    if (rst) rp <= 0;
    else if (fifo_rd && !fifo_empty) rp <= rp + 1;
  end

  // Stream monitor
  bit bit_q [$];
  int done_cnt = 0;
  int done_off = 0;
  int falls = 0;
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (tx_valid) bit_q.push_back(tx_bit);
    if (tx_done) begin
      done_cnt++;
      if (!tx_valid || busy) done_off++;
    end
    if (prev_v && !tx_valid) falls++;
    prev_v = tx_valid;
  end

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] pay [0:63];
  logic [7:0] exp_q [$];
  int base_bits, d0, f0, rp0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d,
                                           input logic sel);
    logic [15:0] p = sel ? 16'h1021 : 16'h8005;
    for (int b = 7; b >= 0; b--) begin
      logic fb = c[15] ^ d[b];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  task automatic build_expected(input int avail);
    logic [15:0] c = 16'hFFFF;
    int np = (c_pre == 0) ? 1 : int'(c_pre);
    int nh = (c_hdr_len > 4) ? 4 : int'(c_hdr_len);
    exp_q.delete();
    for (int i = 0; i < np; i++) exp_q.push_back(8'h55);
    for (int i = 0; i <= int'(c_sync_len); i++) exp_q.push_back(c_sync_word[31-8*i -: 8]);
    for (int i = 0; i < nh; i++) begin
      exp_q.push_back(c_hdr_word[31-8*i -: 8]);
      c = crc_byte(c, c_hdr_word[31-8*i -: 8], c_crc_sel);
    end
    if (c_len_en) begin
      exp_q.push_back(c_pay_len);
      c = crc_byte(c, c_pay_len, c_crc_sel);
    end
    for (int i = 0; i < int'(c_pay_len); i++) begin
      if (i >= avail) return;
      exp_q.push_back(pay[i]);
      c = crc_byte(c, pay[i], c_crc_sel);
    end
    if (c_crc_en) begin
      exp_q.push_back(c[15:8]);
      exp_q.push_back(c[7:0]);
    end
  endtask

  task automatic start_pkt(input int avail);
    for (int i = 0; i < avail; i++) begin
      fmem[wp[5:0]] = pay[i];
      wp++;
    end
    base_bits = bit_q.size();
    d0 = done_cnt;
    f0 = falls;
    rp0 = rp;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_pkt(input string req);
    int t = 0;
    while (done_cnt == d0 && !tx_err && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 5000, req, "packet end timeout", t, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    int got = bit_q.size() - base_bits;
    int bad_at = -1;
    chk(got == exp_q.size() * 8, req, "bit count", got, exp_q.size() * 8);
    for (int i = 0; i < exp_q.size() && bad_at < 0; i++)
      for (int b = 7; b >= 0; b--)
        if (base_bits + i*8 + 7 - b < bit_q.size())
          if (bit_q[base_bits + i*8 + 7 - b] != exp_q[i][b] && bad_at < 0) bad_at = i;
    chk(bad_at < 0, req, "stream byte index mismatch", bad_at, -1);
  endtask

  function automatic logic [15:0] last16();
    logic [15:0] v = '0;
    for (int i = 16; i >= 1; i--) v = {v[14:0], bit_q[bit_q.size() - i]};
    return v;
  endfunction

  task automatic t_reset();
    chk(!tx_valid && !tx_bit, "R10", "tx outputs after reset", {tx_valid, tx_bit}, 0);
    chk(!busy && !tx_done && !tx_err, "R10", "status after reset", {busy, tx_done, tx_err}, 0);
    chk(!fifo_rd, "R10", "fifo_rd after reset", fifo_rd, 0);
  endtask

  task automatic t_basic();
    c_pre = 8'd2; c_sync_len = 2'd1; c_sync_word = 32'hD391_0000;
    c_hdr_len = 3'd2; c_hdr_word = 32'hABCD_0000; c_len_en = 1'b1;
    c_pay_len = 8'd4; c_crc_en = 1'b1; c_crc_sel = 1'b1;
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'h10 + 8'(i * 7));
    build_expected(64);
    start_pkt(4);
    wait_pkt("R1");
    cmp_stream("R1");
    chk(bit_q[base_bits] == 1'b0, "R2", "first preamble bit", bit_q[base_bits], 0);
    chk(done_cnt == d0 + 1 && done_off == 0, "R7", "done pulse with last bit", done_cnt - d0, 1);
    chk(falls == f0 + 1, "R4", "tx_valid breaks", falls - f0, 1);
    chk(rp - rp0 == 4, "R5", "fifo pops", rp - rp0, 4);
    chk(!busy && !tx_err, "R7", "idle after packet", {busy, tx_err}, 0);
  endtask

  task automatic t_minimal();
    c_pre = 8'd1; c_sync_len = 2'd0; c_sync_word = 32'h2D00_0000;
    c_hdr_len = 3'd0; c_len_en = 1'b0; c_pay_len = 8'd3; c_crc_en = 1'b0;
    pay[0] = 8'h81; pay[1] = 8'h00; pay[2] = 8'hFE;
    build_expected(64);
    start_pkt(3);
    wait_pkt("R1");
    cmp_stream("R1");
    chk(rp - rp0 == 3, "R5", "fifo pops minimal", rp - rp0, 3);
  endtask

  task automatic t_wide();
    c_pre = 8'd3; c_sync_len = 2'd3; c_sync_word = 32'h1234_5678;
    c_hdr_len = 3'd7; c_hdr_word = 32'h9ABC_DEF0; c_len_en = 1'b1;
    c_pay_len = 8'd5; c_crc_en = 1'b1; c_crc_sel = 1'b0;
    for (int i = 0; i < 5; i++) pay[i] = 8'(8'hC3 ^ 8'(i * 29));
    build_expected(64);
    start_pkt(5);
    wait_pkt("R3");
    cmp_stream("R3");
  endtask

  task automatic t_crc_vec(input logic sel, input logic [15:0] ref_v);
    c_pre = 8'd1; c_sync_len = 2'd0; c_hdr_len = 3'd0; c_len_en = 1'b0;
    c_pay_len = 8'd9; c_crc_en = 1'b1; c_crc_sel = sel;
    for (int i = 0; i < 9; i++) pay[i] = 8'(8'h31 + i);
    build_expected(64);
    start_pkt(9);
    wait_pkt("R6");
    cmp_stream("R6");
    chk(last16() == ref_v, "R6", "check value", last16(), ref_v);
  endtask

  task automatic t_pre_edges();
    c_pre = 8'd0; c_sync_len = 2'd0; c_sync_word = 32'hF000_0000;
    c_hdr_len = 3'd0; c_len_en = 1'b0; c_pay_len = 8'd1; c_crc_en = 1'b0;
    pay[0] = 8'h5A;
    build_expected(64);
    start_pkt(1);
    wait_pkt("R2");
    cmp_stream("R2");
    c_pre = 8'd255; c_hdr_len = 3'd1; c_hdr_word = 32'h7700_0000;
    c_len_en = 1'b1; c_pay_len = 8'd0; c_crc_en = 1'b1; c_crc_sel = 1'b1;
    build_expected(64);
    start_pkt(0);
    wait_pkt("R2");
    cmp_stream("R2");
    chk(rp == rp0, "R5", "no pops for empty payload", rp - rp0, 0);
  endtask

  task automatic t_underflow();
    int nb;
    c_pre = 8'd1; c_sync_len = 2'd1; c_sync_word = 32'hAA55_0000;
    c_hdr_len = 3'd1; c_hdr_word = 32'h3C00_0000; c_len_en = 1'b1;
    c_pay_len = 8'd6; c_crc_en = 1'b1; c_crc_sel = 1'b0;
    for (int i = 0; i < 6; i++) pay[i] = 8'(8'h60 + i);
    build_expected(2);
    start_pkt(2);
    wait_pkt("R8");
    cmp_stream("R8");
    chk(tx_err == 1'b1, "R8", "error flag", tx_err, 1);
    chk(done_cnt == d0, "R8", "no done on abort", done_cnt - d0, 0);
    nb = bit_q.size();
    repeat (20) @(negedge clk);
    chk(tx_err == 1'b1 && !busy, "R8", "error held while idle", tx_err, 1);
    chk(bit_q.size() == nb, "R8", "no bits after abort", bit_q.size() - nb, 0);
  endtask

  task automatic t_busy_ignore();
    c_pre = 8'd2; c_sync_len = 2'd1; c_sync_word = 32'hC0DE_0000;
    c_hdr_len = 3'd2; c_hdr_word = 32'h1122_0000; c_len_en = 1'b1;
    c_pay_len = 8'd3; c_crc_en = 1'b1; c_crc_sel = 1'b1;
    for (int i = 0; i < 3; i++) pay[i] = 8'(8'hA0 + i);
    build_expected(64);
    start_pkt(3);
    @(negedge clk);
    chk(tx_err == 1'b0, "R8", "error cleared by start", tx_err, 0);
    repeat (30) @(negedge clk);
    c_sync_word = 32'hFFFF_FFFF; c_pre = 8'd9; c_hdr_word = 32'h0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_pkt("R9");
    cmp_stream("R9");
    repeat (40) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9", "single packet for two starts", done_cnt - d0, 1);
    chk(!busy && !tx_valid, "R9", "no second packet", {busy, tx_valid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_minimal();
    t_wide();
    t_crc_vec(1'b1, 16'h29B1);
    t_crc_vec(1'b0, 16'hAEE7);
    t_pre_edges();
    t_underflow();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule